// File: doc/BRIEF.md
# Transmit Header Ring Framer

This block drains a ring of outgoing packet descriptors that software fills in memory and turns each one into a framed byte stream for the link. Every ring entry starts with ten bytes that only the block uses: where the payload lives, how long it is, and how long the header that follows is. The header bytes come after these ten bytes. The block keeps those ten bytes to itself. On the link it sends a new-header marker, the header bytes, a payload marker and then the payload bytes, which it fetches from a separate payload memory.

Software tells the block how far it has written by moving a producer index, counted in ring bytes. The block reports how far it has read through a consumer cursor in the same units. Both carry one bit more than the ring address. Equal values mean the ring is empty, and values that differ only in that top bit mean the ring is full. The two memory read ports return data one cycle after the read enable. The output is a byte with a marker flag, handed over with valid and ready.

Top module: `tx_ring_framer`

## Requirements
- R1: While reset is held and right after its release, `out_valid`, `hdr_rd_en` and `pay_rd_en` are 0 and `cons_idx` is 0.
- R2: An entry is processed only while `cons_idx` differs from `prod_idx` over all RING_AW+1 bits. When they are equal there are no reads and no output. A ring that is completely full, where the two values differ only in the top bit, is drained entirely.
- R3: The ten leading bytes of an entry are little-endian. Offsets 0..5 hold the payload address, offsets 6..7 the payload size in bytes, and offsets 8..9 the header length in bytes. None of these ten bytes appears on the output.
- R4: Each entry is sent in this order. First a marker beat with `out_sym`=1 and `out_data`=0x01. Then the header bytes as data beats (`out_sym`=0), in ring order, starting at entry offset 10. Then a marker beat with `out_sym`=1 and `out_data`=0x02. Then the payload bytes as data beats, where byte i is read at payload address base+i (48-bit sum).
- R5: Header ring addresses are taken modulo 2^RING_AW, so an entry may run past the end of the ring and continue at address 0.
- R6: Once an entry has been fully fetched, `cons_idx` advances by 10 plus the header length, modulo 2^(RING_AW+1). It never moves by less than 10.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output beat stays unchanged. No beat is lost or sent twice.
- R8: A header length of 0 puts the 0x02 marker directly after the 0x01 marker. A payload size of 0 sends the 0x02 marker with no payload bytes after it.
- R9: With `out_ready` held at 1, the payload bytes of one entry leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_idx | input | RING_AW+1 | Software producer index in ring bytes, with wrap bit |
| cons_idx | output | RING_AW+1 | Hardware consumer cursor in ring bytes, with wrap bit |
| hdr_rd_en | output | 1 | Header ring read enable |
| hdr_rd_addr | output | RING_AW | Header ring byte address |
| hdr_rd_data | input | 8 | Header ring read data, one cycle after enable |
| pay_rd_en | output | 1 | Payload memory read enable |
| pay_rd_addr | output | PAY_AW | Payload memory byte address |
| pay_rd_data | input | 8 | Payload read data, one cycle after enable |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | 8 | Output byte or marker code |
| out_sym | output | 1 | 1 when the beat is a marker |

## Verification
The bench sweeps header lengths from 0 to 20 against several payload sizes under three ready patterns. With a 64-byte ring, many entries therefore straddle the ring end. A wrong wrap would read stale bytes and corrupt the stream, and a wrong cursor step would stop the drain or run it past the producer. Zero-length headers and payloads catch designs that emit a spurious byte or hang on an empty count. Random and alternating stalls catch a skid path that drops or repeats a byte, and an always-ready phase catches a design that inserts a bubble between payload bytes. A batch of entries and a ring filled exactly to capacity catch an emptiness test that ignores the wrap bit, which would leave the full ring undrained.

// File: rtl/txf_pkg.sv
package txf_pkg;

    // bytes of memory-side metadata leading each entry
    localparam int META_BYTES = 10;

    // marker codes carried with out_sym = 1
    localparam logic [7:0] SYM_NEW_HDR = 8'h01;
    localparam logic [7:0] SYM_PAYLOAD = 8'h02;

    typedef struct packed {
        logic       sym;
        logic [7:0] data;
    } item_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_META,
        ST_SYMH,
        ST_HDR,
        ST_SYMP,
        ST_PAY
    } fsm_e;

    // what the read issued last cycle will deliver
    typedef enum logic [2:0] {
        K_META,
        K_SYMH,
        K_SYMP,
        K_HDR,
        K_PAY
    } kind_e;

endpackage

// File: rtl/txf_outq.sv
// Two-entry output queue with a credit rule that lets the sequencer
// issue a one-cycle-latency read every cycle without overrunning it.
module txf_outq
    import txf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_v,
    input  item_t      push_item,
    input  logic       inflight,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sym,
    output logic       room
);

    typedef struct packed {
        item_t      e0;
        item_t      e1;
        logic [1:0] occ;
    } oq_t;

    oq_t        st_d, st_q;
    logic       pop;
    logic [2:0] load;

    always_comb begin
        st_d = st_q;
        pop  = (st_q.occ != 2'd0) && out_ready;
        if (pop) begin
            st_d.e0  = st_q.e1;
            st_d.occ = st_q.occ - 2'd1;
        end
        if (push_v) begin
            if (st_d.occ == 2'd0) begin
                st_d.e0 = push_item;
            end else begin
                st_d.e1 = push_item;
            end
            st_d.occ = st_d.occ + 2'd1;
        end
        // a read issued now lands next cycle and needs a free slot then
        load = {1'b0, st_q.occ} + {2'b00, inflight};
        room = pop ? (load <= 3'd2) : (load <= 3'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = (st_q.occ != 2'd0);
    assign out_data  = st_q.e0.data;
    assign out_sym   = st_q.e0.sym;

endmodule

// File: rtl/txf_seq.sv
// Entry sequencer: fetches metadata, then issues marker, header and
// payload items in link order, and advances the consumer cursor.
module txf_seq
    import txf_pkg::*;
#(
    parameter int RING_AW = 12,
    parameter int PAY_AW  = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RING_AW:0]   prod_idx,
    input  logic               room,
    output logic               hdr_rd_en,
    output logic [RING_AW-1:0] hdr_rd_addr,
    input  logic [7:0]         hdr_rd_data,
    output logic               pay_rd_en,
    output logic [PAY_AW-1:0]  pay_rd_addr,
    input  logic [7:0]         pay_rd_data,
    output logic               push_v,
    output item_t              push_item,
    output logic               inflight,
    output logic [RING_AW:0]   cons_idx
);

    localparam int CW = RING_AW + 1;

    typedef struct packed {
        fsm_e          fsm;
        logic [15:0]   cnt;
        logic [CW-1:0] cons;
        logic [47:0]   paddr;
        logic [15:0]   psize;
        logic [15:0]   hlen;
        logic          pend_v;
        kind_e         pend_k;
        logic [3:0]    pend_idx;
    } seq_t;

    seq_t        st_d, st_q;
    logic [15:0] hdr_off;

    always_comb begin
        st_d        = st_q;
        st_d.pend_v = 1'b0;
        hdr_rd_en   = 1'b0;
        hdr_rd_addr = '0;
        pay_rd_en   = 1'b0;
        pay_rd_addr = '0;
        push_v      = 1'b0;
        push_item   = '0;
        hdr_off     = 16'(META_BYTES) + st_q.cnt;

        // data returned for last cycle's request
        if (st_q.pend_v) begin
            case (st_q.pend_k)
                K_META: begin
                    case (st_q.pend_idx)
                        4'd0:    st_d.paddr[7:0]   = hdr_rd_data;
                        4'd1:    st_d.paddr[15:8]  = hdr_rd_data;
                        4'd2:    st_d.paddr[23:16] = hdr_rd_data;
                        4'd3:    st_d.paddr[31:24] = hdr_rd_data;
                        4'd4:    st_d.paddr[39:32] = hdr_rd_data;
                        4'd5:    st_d.paddr[47:40] = hdr_rd_data;
                        4'd6:    st_d.psize[7:0]   = hdr_rd_data;
                        4'd7:    st_d.psize[15:8]  = hdr_rd_data;
                        4'd8:    st_d.hlen[7:0]    = hdr_rd_data;
                        4'd9:    st_d.hlen[15:8]   = hdr_rd_data;
                        default: ;
                    endcase
                end
                K_SYMH: begin
                    push_v    = 1'b1;
                    push_item = '{sym: 1'b1, data: SYM_NEW_HDR};
                end
                K_SYMP: begin
                    push_v    = 1'b1;
                    push_item = '{sym: 1'b1, data: SYM_PAYLOAD};
                end
                K_HDR: begin
                    push_v    = 1'b1;
                    push_item = '{sym: 1'b0, data: hdr_rd_data};
                end
                K_PAY: begin
                    push_v    = 1'b1;
                    push_item = '{sym: 1'b0, data: pay_rd_data};
                end
                default: ;
            endcase
        end

        case (st_q.fsm)
            ST_IDLE: begin
                if (prod_idx != st_q.cons) begin
                    st_d.fsm = ST_META;
                    st_d.cnt = '0;
                end
            end
            ST_META: begin
                hdr_rd_en     = 1'b1;
                hdr_rd_addr   = st_q.cons[RING_AW-1:0] + RING_AW'(st_q.cnt);
                st_d.pend_v   = 1'b1;
                st_d.pend_k   = K_META;
                st_d.pend_idx = st_q.cnt[3:0];
                if (st_q.cnt == 16'(META_BYTES - 1)) begin
                    st_d.fsm = ST_SYMH;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 16'd1;
                end
            end
            ST_SYMH: begin
                if (room) begin
                    st_d.pend_v = 1'b1;
                    st_d.pend_k = K_SYMH;
                    st_d.fsm    = ST_HDR;
                    st_d.cnt    = '0;
                end
            end
            ST_HDR: begin
                if (st_q.cnt == st_q.hlen) begin
                    st_d.fsm = ST_SYMP;
                end else if (room) begin
                    hdr_rd_en   = 1'b1;
                    hdr_rd_addr = st_q.cons[RING_AW-1:0] + RING_AW'(hdr_off);
                    st_d.pend_v = 1'b1;
                    st_d.pend_k = K_HDR;
                    st_d.cnt    = st_q.cnt + 16'd1;
                end
            end
            ST_SYMP: begin
                if (room) begin
                    st_d.pend_v = 1'b1;
                    st_d.pend_k = K_SYMP;
                    st_d.fsm    = ST_PAY;
                    st_d.cnt    = '0;
                end
            end
            ST_PAY: begin
                if (st_q.cnt == st_q.psize) begin
                    st_d.cons = st_q.cons + CW'(st_q.hlen) + CW'(META_BYTES);
                    st_d.fsm  = ST_IDLE;
                end else if (room) begin
                    pay_rd_en   = 1'b1;
                    pay_rd_addr = PAY_AW'(st_q.paddr + 48'(st_q.cnt));
                    st_d.pend_v = 1'b1;
                    st_d.pend_k = K_PAY;
                    st_d.cnt    = st_q.cnt + 16'd1;
                end
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inflight = st_q.pend_v && (st_q.pend_k != K_META);
    assign cons_idx = st_q.cons;

endmodule

// File: rtl/tx_ring_framer.sv
module tx_ring_framer
    import txf_pkg::*;
#(
    parameter int RING_AW = 12,
    parameter int PAY_AW  = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RING_AW:0]   prod_idx,
    output logic [RING_AW:0]   cons_idx,
    output logic               hdr_rd_en,
    output logic [RING_AW-1:0] hdr_rd_addr,
    input  logic [7:0]         hdr_rd_data,
    output logic               pay_rd_en,
    output logic [PAY_AW-1:0]  pay_rd_addr,
    input  logic [7:0]         pay_rd_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data,
    output logic               out_sym
);

    logic  room;
    logic  push_v;
    item_t push_item;
    logic  inflight;

    txf_seq #(
        .RING_AW (RING_AW),
        .PAY_AW  (PAY_AW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .prod_idx    (prod_idx),
        .room        (room),
        .hdr_rd_en   (hdr_rd_en),
        .hdr_rd_addr (hdr_rd_addr),
        .hdr_rd_data (hdr_rd_data),
        .pay_rd_en   (pay_rd_en),
        .pay_rd_addr (pay_rd_addr),
        .pay_rd_data (pay_rd_data),
        .push_v      (push_v),
        .push_item   (push_item),
        .inflight    (inflight),
        .cons_idx    (cons_idx)
    );

    txf_outq u_outq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_v    (push_v),
        .push_item (push_item),
        .inflight  (inflight),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sym   (out_sym),
        .room      (room)
    );

endmodule

// File: rtl/tx_ring_framer_chk.sv
module tx_ring_framer_chk
    import txf_pkg::*;
#(
    parameter int RING_AW = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RING_AW:0]   prod_idx,
    input logic [RING_AW:0]   cons_idx,
    input logic               out_valid,
    input logic               out_ready,
    input logic [7:0]         out_data,
    input logic               out_sym
);

    localparam int CW = RING_AW + 1;

    // set after a new-header marker leaves, cleared by a payload marker
    logic hs_open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_open_q <= 1'b0;
        end else if (out_valid && out_ready && out_sym) begin
            hs_open_q <= (out_data == SYM_NEW_HDR);
        end
    end

    // R7: a stalled beat is held unchanged
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sym));

    // R2: an empty ring leaves the cursor where it is
    assert_empty_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_idx == prod_idx) |=> $stable(cons_idx));

    // R6: each cursor move covers at least the metadata bytes
    assert_cursor_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cons_idx) |-> (CW'(cons_idx - $past(cons_idx)) >= CW'(META_BYTES)));

    // R4: marker beats use only the two codes
    assert_marker_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sym |-> (out_data == SYM_NEW_HDR) || (out_data == SYM_PAYLOAD));

    // R4: payload marker only after a new-header marker
    assert_marker_order_pm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_sym && (out_data == SYM_PAYLOAD) |-> hs_open_q);

    // R4: no second new-header marker before the payload marker
    assert_marker_order_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_sym && (out_data == SYM_NEW_HDR) |-> !hs_open_q);

endmodule

bind tx_ring_framer tx_ring_framer_chk #(.RING_AW(RING_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prod_idx  (prod_idx),
    .cons_idx  (cons_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sym   (out_sym)
);

// File: tb/tx_ring_framer_tb.sv
module tx_ring_framer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RAW        = 6;
    localparam int PAW        = 48;
    localparam int RSZ        = 1 << RAW;
    localparam int CW         = RAW + 1;
    localparam int LIMIT      = 150000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [CW-1:0]  prod_idx = '0;
    logic [CW-1:0]  cons_idx;
    logic           hdr_rd_en;
    logic [RAW-1:0] hdr_rd_addr;
    logic [7:0]     hdr_rd_data;
    logic           pay_rd_en;
    logic [PAW-1:0] pay_rd_addr;
    logic [7:0]     pay_rd_data;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [7:0]     out_data;
    logic           out_sym;

    tx_ring_framer #(.RING_AW(RAW), .PAY_AW(PAW)) u_dut (
        .clk(clk), .rst_n(rst_n), .prod_idx(prod_idx), .cons_idx(cons_idx),
        .hdr_rd_en(hdr_rd_en), .hdr_rd_addr(hdr_rd_addr), .hdr_rd_data(hdr_rd_data),
        .pay_rd_en(pay_rd_en), .pay_rd_addr(pay_rd_addr), .pay_rd_data(pay_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sym(out_sym)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pdat(input logic [47:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ a[39:32] ^ a[47:40] ^ 8'h5A;
    endfunction

    // memories with one cycle of read latency
    logic [7:0] ring [0:RSZ-1];
    always @(posedge clk) begin
        if (hdr_rd_en) hdr_rd_data <= ring[hdr_rd_addr];
        if (pay_rd_en) pay_rd_data <= pdat(pay_rd_addr);
    end

    // expected stream: {sym,data}; kind 0 header, 1 marker, 2 payload
    logic [8:0] exp_item [0:8191];
    logic [1:0] exp_kind [0:8191];
    int exp_wr = 0;
    int exp_rd = 0;

    int checks = 0, errs = 0, m_checks = 0, m_errs = 0;
    int cyc = 0;
    int rdy_mode = 0;
    logic [CW-1:0] wp = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT) begin
            $display("FAIL watchdog R6 cycles %0d expected below %0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks + m_checks + 1, errs + m_errs + 1);
            $finish;
        end
    end

    // output monitor and ready driver
    logic [7:0] lfsr = 8'h01;
    logic       hold_v = 1'b0;
    logic [7:0] hold_d = '0;
    logic       hold_s = 1'b0;
    logic       last_pay = 1'b0;
    int         last_cyc = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            hold_v   = 1'b0;
            last_pay = 1'b0;
        end else begin
            logic r;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (rdy_mode)
                1:       r = lfsr[0] | lfsr[2];
                2:       r = cyc[0];
                default: r = 1'b1;
            endcase
            out_ready = r;
            if (hold_v) begin
                m_checks++;
                if (!(out_valid && out_data == hold_d && out_sym == hold_s)) begin
                    m_errs++;
                    $display("FAIL R7 stalled beat v=%0b %0b/%02h expected 1 %0b/%02h",
                             out_valid, out_sym, out_data, hold_s, hold_d);
                end
            end
            hold_v = out_valid && !r;
            hold_d = out_data;
            hold_s = out_sym;
            if (out_valid && r) begin
                m_checks++;
                if (exp_rd >= exp_wr) begin
                    m_errs++;
                    $display("FAIL R2 unexpected beat %0b/%02h expected none", out_sym, out_data);
                end else begin
                    if ({out_sym, out_data} != exp_item[exp_rd]) begin
                        m_errs++;
                        $display("FAIL R3 R4 R5 R8 beat %0d got %03h expected %03h",
                                 exp_rd, {out_sym, out_data}, exp_item[exp_rd]);
                    end
                    if (rdy_mode == 0 && exp_kind[exp_rd] == 2'd2 && last_pay) begin
                        m_checks++;
                        if (cyc != last_cyc + 1) begin
                            m_errs++;
                            $display("FAIL R9 payload gap %0d expected 1", cyc - last_cyc);
                        end
                    end
                    last_pay = (exp_kind[exp_rd] == 2'd2);
                    last_cyc = cyc;
                    exp_rd++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s got %0d expected %0d", what, act, expv);
        end
    endtask

    task automatic push_exp(input logic s, input logic [7:0] d, input logic [1:0] k);
        exp_item[exp_wr] = {s, d};
        exp_kind[exp_wr] = k;
        exp_wr++;
    endtask

    task automatic wr_ring(input int off, input logic [7:0] b);
        ring[(int'(wp[RAW-1:0]) + off) % RSZ] = b;
    endtask

    task automatic put_entry(input logic [47:0] pa, input logic [15:0] ps,
                             input logic [15:0] hl, input logic [7:0] seed);
        for (int i = 0; i < 6; i++) wr_ring(i, pa[8*i +: 8]);
        wr_ring(6, ps[7:0]);
        wr_ring(7, ps[15:8]);
        wr_ring(8, hl[7:0]);
        wr_ring(9, hl[15:8]);
        push_exp(1'b1, 8'h01, 2'd1);
        for (int j = 0; j < int'(hl); j++) begin
            logic [7:0] b;
            b = (j == 0) ? 8'h00 : 8'(int'(seed) + j * 5);
            wr_ring(10 + j, b);
            push_exp(1'b0, b, 2'd0);
        end
        push_exp(1'b1, 8'h02, 2'd1);
        for (int j = 0; j < int'(ps); j++) push_exp(1'b0, pdat(pa + 48'(j)), 2'd2);
        wp = wp + CW'(10 + int'(hl));
    endtask

    task automatic publish();
        @(negedge clk);
        prod_idx = wp;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        @(negedge clk);
        while (!(exp_rd == exp_wr && cons_idx == wp && !out_valid) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(cons_idx == wp, {tag, " cursor"}, int'(cons_idx), int'(wp));
        check(exp_rd == exp_wr, {tag, " beats sent"}, exp_rd, exp_wr);
    endtask

    initial begin
        int seed = 1;
        bit quiet = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid && !hdr_rd_en && !pay_rd_en, "R1 idle outputs in reset", int'(out_valid), 0);
        check(cons_idx == '0, "R1 cursor in reset", int'(cons_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && cons_idx == '0, "R1 after release", int'(cons_idx), 0);

        // R2: equal indices, nothing happens
        repeat (40) begin
            @(negedge clk);
            if (hdr_rd_en || pay_rd_en || out_valid) quiet = 1'b0;
        end
        check(quiet, "R2 no activity while empty", int'(quiet), 1);

        // sweep of header length, payload size and ready pattern
        for (int m = 0; m < 3; m++) begin
            rdy_mode = m;
            for (int hl = 0; hl <= 20; hl++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    int ps;
                    string tag;
                    logic [47:0] pa;
                    ps = (pi == 3) ? 5 : pi;
                    pa = {8'(8'hC0 ^ seed), 8'h11, 8'(seed * 3), 8'hFF, 8'hFF, 8'(8'hF0 + seed % 16)};
                    if (hl == 0 || ps == 0) tag = "R8";
                    else if (int'(wp[RAW-1:0]) + 10 + hl > RSZ) tag = "R5 R6";
                    else tag = "R6";
                    put_entry(pa, 16'(ps), 16'(hl), 8'(seed));
                    publish();
                    drain(tag);
                    seed++;
                end
            end
        end

        // several entries published at once under random stalls
        rdy_mode = 1;
        put_entry(48'h0000_0000_0010, 16'd3, 16'd6, 8'h21);
        put_entry(48'h1234_5678_9AFE, 16'd4, 16'd8, 8'h42);
        put_entry(48'hFFFF_FFFF_FFFF, 16'd2, 16'd10, 8'h63);
        publish();
        drain("R6 batch");

        // completely full ring: indices differ only in the wrap bit
        for (int m = 0; m < 2; m++) begin
            rdy_mode = (m == 0) ? 0 : 1;
            put_entry(48'h0000_00AB_0000, 16'd4, 16'd22, 8'h10);
            put_entry(48'h0000_00CD_0100, 16'd6, 16'd22, 8'h30);
            check((wp ^ cons_idx) == CW'(RSZ), "R2 full ring setup", int'(wp ^ cons_idx), RSZ);
            publish();
            drain("R2 full ring");
        end

        $display("CHECKS %0d ERRORS %0d", checks + m_checks, errs + m_errs);
        $finish;
    end

endmodule